// File: doc/BRIEF.md
# Remapping Global Command/Status Controller

This block holds the global command and global status registers of an address and interrupt remapping unit. Software writes a 32-bit command word over a simple register bus. Each command field is a write-only trigger. The block turns it into a request toward an internal engine, and the outcome shows up later as a bit in a separate, read-only status register.

Three commands are handled:

- **Write-buffer flush.** A request/done handshake toward the posting buffers.
- **Queued-invalidation enable.** An enable level toward the invalidation engine. Its status copy follows only once that engine reports idle.
- **Interrupt-remapping enable.** The remapping mode switches only at a transaction boundary. The block counts interrupts that have been accepted but not yet completed. While a mode change is pending it holds off new interrupts with a stall output, and it commits the change only once that count reaches zero. Each interrupt is therefore handled wholly in one mode.

Top module: `remap_gcmd_ctrl`

## Requirements
- R1: After reset the following are all 0: the status register, `flush_req`, `qinv_en`, `irmap_active`, `irq_stall`, the in-flight count and `reg_rdata`.
- R2: Read data is registered and appears in the cycle after `reg_rd`. A read of the command register (offset 0x18) returns zero, and so does a read of any offset other than 0x18 or 0x1C.
- R3: A command write with bit 27 set, made while no flush is pending, raises `flush_req` from the next cycle. Status bit 27 then reads 1.
- R4: A pending flush stays pending until a clock edge at which `flush_done` is high, and clears at that edge. A further flush request while one is pending is ignored. Writing 0 to bit 27 has no effect.
- R5: Every command write copies bit 26 onto `qinv_en` from the next cycle.
- R6: Status bit 26 takes the value of `qinv_en` only at a clock edge where `qinv_idle` is high.
- R7: Every command write stores bit 25 as the requested remapping mode. `irq_stall` is high whenever the requested mode differs from the active mode.
- R8: `irmap_active`, which is also status bit 25, takes the requested mode only at a clock edge where the in-flight count is zero.
- R9: The in-flight count rises by one on `irq_accept` when `irq_stall` is low, and falls by one on `irq_complete` when it is nonzero. An accept while stalled is not counted, and a completion at zero is ignored.
- R10: `irq_stall` is high while the in-flight count is at its maximum, 2^CNT_W-1, so the count never wraps.
- R11: The status register at offset 0x1C is read-only and writes to it change nothing. It returns flush pending at bit 27, queued-invalidation status at bit 26 and remapping status at bit 25. All its other bits read 0.
- R12: A single command write acts on all three fields at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| flush_req | output | 1 | Flush request to the write buffers, held until done |
| flush_done | input | 1 | Flush completion from the write buffers |
| qinv_en | output | 1 | Requested enable for the invalidation engine |
| qinv_idle | input | 1 | Invalidation engine idle |
| irq_accept | input | 1 | An interrupt request enters the unit |
| irq_complete | input | 1 | An in-flight interrupt request finishes |
| irq_stall | output | 1 | Hold off new interrupt requests |
| irmap_active | output | 1 | Remapping mode applied to interrupts |

## Verification
The interrupt drain is swept over every in-flight depth from zero to the full count of seven, with the mode toggled on each pass. This separates a switch that waits for exactly the right number of completions from one that switches early, and from one that counts a stalled accept or wraps past the maximum. The flush handshake is held for zero to five cycles, with a duplicate request placed mid-flight, so that a pending flush that ends early or restarts on the duplicate is exposed. The invalidation status is held off by a busy engine in both directions. A combined command and writes to the status register check that the fields act independently and that the status register is read-only.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CMD  = 2'd1,
      SEL_STS  = 2'd2
   } gcs_sel_e;

   typedef struct packed {
      logic flush_busy;
      logic qinv_on;
      logic irmap_on;
   } gcs_status_t;

   typedef struct packed {
      logic flush;
      logic qinv;
      logic irmap;
   } gcs_cmd_t;

endpackage

// File: rtl/gcs_regbus_dec.sv
module gcs_regbus_dec
   import gcs_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter logic [31:0] CMD_OFF   = 32'h18,
   parameter logic [31:0] STS_OFF   = 32'h1C,
   parameter int          FLUSH_BIT = 27,
   parameter int          QINV_BIT  = 26,
   parameter int          IRMAP_BIT = 25,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  gcs_status_t       sts_i,
   output logic              cmd_wr_o,
   output gcs_cmd_t          cmd_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] CMD_A = CMD_OFF[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] STS_A = STS_OFF[ADDR_W-1:0];

   gcs_sel_e          sel;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      if (addr_i == CMD_A)      sel = SEL_CMD;
      else if (addr_i == STS_A) sel = SEL_STS;
      else                      sel = SEL_NONE;
   end

   // Only the command register accepts writes; the status register is read-only.
   assign cmd_wr_o    = wr_i && (sel == SEL_CMD);
   assign cmd_o.flush = wdata_i[FLUSH_BIT];
   assign cmd_o.qinv  = wdata_i[QINV_BIT];
   assign cmd_o.irmap = wdata_i[IRMAP_BIT];

   always_comb begin
      rd_mux = '0;
      if (sel == SEL_STS) begin
         rd_mux[FLUSH_BIT] = sts_i.flush_busy;
         rd_mux[QINV_BIT]  = sts_i.qinv_on;
         rd_mux[IRMAP_BIT] = sts_i.irmap_on;
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rdata_q <= '0;
            else if (rd_i) rdata_q <= rd_mux;
            else           rdata_q <= '0;
         end
         assign rdata_o = rdata_q;
      end else begin : g_rd_comb
         assign rdata_o = rd_i ? rd_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/gcs_flush_ctl.sv
module gcs_flush_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   output logic busy_o
);

   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  busy_q <= 1'b0;
      else if (busy_q && done_i)   busy_q <= 1'b0;
      else if (!busy_q && start_i) busy_q <= 1'b1;
   end

   assign busy_o = busy_q;

endmodule

// File: rtl/gcs_qinv_ctl.sv
module gcs_qinv_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic val_i,
   input  logic idle_i,
   output logic en_o,
   output logic sts_o
);

   logic req_q;
   logic sts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    req_q <= 1'b0;
      else if (wr_i) req_q <= val_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts_q <= 1'b0;
      else if (idle_i) sts_q <= req_q;
   end

   assign en_o  = req_q;
   assign sts_o = sts_q;

endmodule

// File: rtl/gcs_irq_drain.sv
module gcs_irq_drain #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             val_i,
   input  logic             accept_i,
   input  logic             complete_i,
   output logic             stall_o,
   output logic             active_o,
   output logic             target_o,
   output logic [CNT_W-1:0] inflight_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             target_q;
   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic             change_pend;
   logic             cnt_full;
   logic             cnt_zero;
   logic             acc_ok;
   logic             cmp_ok;

   assign change_pend = (target_q != active_q);
   assign cnt_full    = (cnt_q == CNT_MAX);
   assign cnt_zero    = (cnt_q == '0);
   assign stall_o     = change_pend | cnt_full;
   assign acc_ok      = accept_i & ~stall_o;
   assign cmp_ok      = complete_i & ~cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    target_q <= 1'b0;
      else if (wr_i) target_q <= val_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(acc_ok) - CNT_W'(cmp_ok);
   end

   // The mode commits only on a transaction boundary: nothing in flight.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       active_q <= 1'b0;
      else if (change_pend && cnt_zero) active_q <= target_q;
   end

   assign active_o   = active_q;
   assign target_o   = target_q;
   assign inflight_o = cnt_q;

endmodule

// File: rtl/remap_gcmd_ctrl.sv
module remap_gcmd_ctrl
   import gcs_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter logic [31:0] CMD_OFF   = 32'h18,
   parameter logic [31:0] STS_OFF   = 32'h1C,
   parameter int          FLUSH_BIT = 27,
   parameter int          QINV_BIT  = 26,
   parameter int          IRMAP_BIT = 25,
   parameter int          CNT_W     = 3,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              flush_req,
   input  logic              flush_done,
   output logic              qinv_en,
   input  logic              qinv_idle,
   input  logic              irq_accept,
   input  logic              irq_complete,
   output logic              irq_stall,
   output logic              irmap_active
);

   initial begin
      assert (FLUSH_BIT < DATA_W && QINV_BIT < DATA_W && IRMAP_BIT < DATA_W)
         else $error("command field outside data word");
      assert (FLUSH_BIT != QINV_BIT && FLUSH_BIT != IRMAP_BIT && QINV_BIT != IRMAP_BIT)
         else $error("command fields overlap");
      assert (CNT_W >= 1 && CNT_W <= 16) else $error("CNT_W out of range");
      assert (CMD_OFF != STS_OFF) else $error("register offsets collide");
      assert (ADDR_W >= 2 && ADDR_W <= 32) else $error("ADDR_W out of range");
   end

   logic             cmd_wr;
   gcs_cmd_t         cmd;
   gcs_status_t      sts;
   logic             qinv_sts;
   logic             irmap_target;
   logic [CNT_W-1:0] inflight;

   gcs_regbus_dec #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CMD_OFF  (CMD_OFF),
      .STS_OFF  (STS_OFF),
      .FLUSH_BIT(FLUSH_BIT),
      .QINV_BIT (QINV_BIT),
      .IRMAP_BIT(IRMAP_BIT),
      .READ_REG (READ_REG)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr),
      .rd_i    (reg_rd),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .sts_i   (sts),
      .cmd_wr_o(cmd_wr),
      .cmd_o   (cmd),
      .rdata_o (reg_rdata)
   );

   gcs_flush_ctl u_flush (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(cmd_wr && cmd.flush),
      .done_i (flush_done),
      .busy_o (flush_req)
   );

   gcs_qinv_ctl u_qinv (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (cmd_wr),
      .val_i (cmd.qinv),
      .idle_i(qinv_idle),
      .en_o  (qinv_en),
      .sts_o (qinv_sts)
   );

   gcs_irq_drain #(.CNT_W(CNT_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (cmd_wr),
      .val_i     (cmd.irmap),
      .accept_i  (irq_accept),
      .complete_i(irq_complete),
      .stall_o   (irq_stall),
      .active_o  (irmap_active),
      .target_o  (irmap_target),
      .inflight_o(inflight)
   );

   assign sts.flush_busy = flush_req;
   assign sts.qinv_on    = qinv_sts;
   assign sts.irmap_on   = irmap_active;

endmodule

// File: rtl/gcs_checker.sv
module gcs_checker #(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter logic [31:0] CMD_OFF   = 32'h18,
   parameter int          FLUSH_BIT = 27,
   parameter int          CNT_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              flush_req,
   input logic              flush_done,
   input logic              qinv_en,
   input logic              qinv_sts,
   input logic              qinv_idle,
   input logic              irq_stall,
   input logic              irmap_active,
   input logic              irmap_target,
   input logic [CNT_W-1:0]  inflight
);

   localparam logic [ADDR_W-1:0] CMD_A   = CMD_OFF[ADDR_W-1:0];
   localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};

   assert_flush_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_req) |-> $past(reg_wr && reg_addr == CMD_A && reg_wdata[FLUSH_BIT]));

   assert_flush_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush_req) |-> $past(flush_done));

   assert_qinv_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(qinv_sts) |-> $past(qinv_idle) && qinv_sts == $past(qinv_en));

   assert_stall_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irmap_target != irmap_active) |-> irq_stall);

   assert_switch_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irmap_active) |-> $past(inflight == '0));

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight == CNT_MAX) |-> irq_stall);

   assert_cmd_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == CMD_A) |=> (reg_rdata == '0));

endmodule

bind remap_gcmd_ctrl gcs_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CMD_OFF  (CMD_OFF),
   .FLUSH_BIT(FLUSH_BIT),
   .CNT_W    (CNT_W)
) u_gcs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .flush_req   (flush_req),
   .flush_done  (flush_done),
   .qinv_en     (qinv_en),
   .qinv_sts    (qinv_sts),
   .qinv_idle   (qinv_idle),
   .irq_stall   (irq_stall),
   .irmap_active(irmap_active),
   .irmap_target(irmap_target),
   .inflight    (inflight)
);

// File: tb/tb_remap_gcmd_ctrl.sv
`timescale 1ns/1ps
module tb_remap_gcmd_ctrl;

   localparam logic [7:0] CMD = 8'h18;
   localparam logic [7:0] STS = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr, reg_rd;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        flush_req, flush_done, qinv_en, qinv_idle;
   logic        irq_accept, irq_complete, irq_stall, irmap_active;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   logic        exp_q, exp_ir, new_ir;
   logic [31:0] rd;

   always #4 clk = ~clk;

   remap_gcmd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .flush_req(flush_req), .flush_done(flush_done), .qinv_en(qinv_en),
      .qinv_idle(qinv_idle), .irq_accept(irq_accept), .irq_complete(irq_complete),
      .irq_stall(irq_stall), .irmap_active(irmap_active)
   );

   function automatic logic [31:0] cmdw(logic f, logic q, logic i);
      return (32'(f) << 27) | (32'(q) << 26) | (32'(i) << 25);
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      flush_done = 1'b0; qinv_idle = 1'b1; irq_accept = 1'b0; irq_complete = 1'b0;
      exp_q = 1'b0; exp_ir = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1", "flush_req", 32'(flush_req), 0);
      chk("R1", "qinv_en", 32'(qinv_en), 0);
      chk("R1", "irmap_active", 32'(irmap_active), 0);
      chk("R1", "irq_stall", 32'(irq_stall), 0);
      chk("R1", "rdata", reg_rdata, 0);
      reg_read(STS, rd); chk("R1", "status", rd, 0);
      reg_read(CMD, rd); chk("R2", "cmd read", rd, 0);

      // R3/R4 flush handshake swept over hold times
      for (int hold = 0; hold < 6; hold++) begin
         reg_write(CMD, cmdw(1'b1, exp_q, exp_ir));
         chk("R3", "flush_req after request", 32'(flush_req), 1);
         reg_read(STS, rd);
         chk("R3", "status flush", rd, cmdw(1'b1, exp_q, exp_ir));
         repeat (hold) @(negedge clk);
         if (hold == 2) reg_write(CMD, cmdw(1'b1, exp_q, exp_ir));
         chk("R4", "flush held", 32'(flush_req), 1);
         flush_done = 1'b1;
         @(negedge clk);
         flush_done = 1'b0;
         chk("R4", "flush cleared", 32'(flush_req), 0);
         reg_write(CMD, cmdw(1'b0, exp_q, exp_ir));
         chk("R4", "zero write no effect", 32'(flush_req), 0);
      end

      // R5/R6 queued invalidation with a busy engine
      qinv_idle = 1'b0;
      reg_write(CMD, cmdw(1'b0, 1'b1, exp_ir));
      chk("R5", "qinv_en on", 32'(qinv_en), 1);
      repeat (3) @(negedge clk);
      reg_read(STS, rd);
      chk("R6", "status held while busy", rd, cmdw(1'b0, 1'b0, exp_ir));
      qinv_idle = 1'b1;
      @(negedge clk);
      qinv_idle = 1'b0;
      reg_read(STS, rd);
      chk("R6", "status after idle", rd, cmdw(1'b0, 1'b1, exp_ir));
      reg_write(CMD, cmdw(1'b0, 1'b0, exp_ir));
      chk("R5", "qinv_en off", 32'(qinv_en), 0);
      reg_read(STS, rd);
      chk("R6", "status held on disable", rd, cmdw(1'b0, 1'b1, exp_ir));
      qinv_idle = 1'b1;
      @(negedge clk);
      reg_read(STS, rd);
      chk("R6", "status disabled", rd, 0);

      // R7-R10 drain sweep over every in-flight depth
      for (int n = 0; n < 8; n++) begin
         for (int k = 0; k < n; k++) begin
            irq_accept = 1'b1;
            @(negedge clk);
         end
         irq_accept = 1'b0;
         chk("R10", $sformatf("stall at depth %0d", n), 32'(irq_stall), (n == 7) ? 1 : 0);
         if (n == 7) begin
            irq_accept = 1'b1;
            @(negedge clk);
            irq_accept = 1'b0;
         end
         new_ir = ~exp_ir;
         reg_write(CMD, cmdw(1'b0, exp_q, new_ir));
         chk("R7", "stall after mode write", 32'(irq_stall), 1);
         chk("R8", "mode held after write", 32'(irmap_active), 32'(exp_ir));
         irq_accept = 1'b1;
         @(negedge clk);
         irq_accept = 1'b0;
         if (n == 0) begin
            chk("R8", "switch with nothing in flight", 32'(irmap_active), 32'(new_ir));
            chk("R7", "stall released", 32'(irq_stall), 0);
         end else begin
            chk("R8", "mode held while in flight", 32'(irmap_active), 32'(exp_ir));
            irq_complete = 1'b1;
            repeat (n) @(negedge clk);
            irq_complete = 1'b0;
            chk("R9", "mode held at drain edge", 32'(irmap_active), 32'(exp_ir));
            chk("R9", "stall at drain edge", 32'(irq_stall), 1);
            @(negedge clk);
            chk("R8", "switch after drain", 32'(irmap_active), 32'(new_ir));
            chk("R7", "stall released after drain", 32'(irq_stall), 0);
         end
         exp_ir = new_ir;
         reg_read(STS, rd);
         chk("R11", "status mode bit", rd, cmdw(1'b0, exp_q, exp_ir));
         irq_complete = 1'b1;
         @(negedge clk);
         irq_complete = 1'b0;
      end

      // R11 status register is read-only; R2 other offsets
      reg_write(STS, 32'hFFFF_FFFF);
      chk("R11", "flush after status write", 32'(flush_req), 0);
      chk("R11", "qinv_en after status write", 32'(qinv_en), 32'(exp_q));
      chk("R11", "mode after status write", 32'(irmap_active), 32'(exp_ir));
      chk("R11", "stall after status write", 32'(irq_stall), 0);
      reg_read(STS, rd);
      chk("R11", "status unchanged", rd, cmdw(1'b0, exp_q, exp_ir));
      reg_read(8'h20, rd);
      chk("R2", "unmapped offset", rd, 0);
      reg_read(CMD, rd);
      chk("R2", "cmd read after writes", rd, 0);

      // R12 all three fields in one write
      new_ir = ~exp_ir;
      reg_write(CMD, cmdw(1'b1, 1'b1, new_ir));
      chk("R12", "flush_req", 32'(flush_req), 1);
      chk("R12", "qinv_en", 32'(qinv_en), 1);
      chk("R12", "stall", 32'(irq_stall), 1);
      flush_done = 1'b1;
      @(negedge clk);
      flush_done = 1'b0;
      chk("R12", "mode switched", 32'(irmap_active), 32'(new_ir));
      exp_ir = new_ir; exp_q = 1'b1;
      reg_read(STS, rd);
      chk("R12", "status combined", rd, cmdw(1'b0, exp_q, exp_ir));

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule